// File: doc/BRIEF.md
# Transmit Character Parity Guard

This block is the input stage of one transmit lane of a serializer. Each character clock it takes a 10-bit character and one odd-parity bit. When checking is on and the parity does not match, it raises a one-cycle status pulse. In the same cycle it puts a fixed, deliberately invalid code group on the data output in place of the character. The far end of the link then sees a bad character instead of a corrupted but legal one. When checking is off, characters pass through unchanged.

The status output also serves a built-in self-test mode. While self-test is enabled, the output stops reporting parity errors. It then pulses once for each complete pass of a 511-step test sequence, which a 9-bit maximal-length LFSR produces. A small two-state machine tracks the mode. In `ST_CHECK` the status reports parity errors. The `START` transition happens when the self-test enable is seen high; it reseeds the LFSR and moves to `ST_TEST`. In `ST_TEST` the LFSR steps once per cycle and the status pulses when the LFSR returns to its seed. The `STOP` transition happens when the self-test enable is seen low and returns to `ST_CHECK`.

Top module: `tx_char_guard`

## Requirements
- R1: The parity check passes when the XOR of the 10 data bits and the parity bit is 1 (odd number of ones). A passing character appears unchanged on `dout` one clock after it is sampled.
- R2: When `chk_en_n` is high, checking is off. Every character appears unchanged on `dout` one clock later, whatever its parity.
- R3: With checking on and self-test off, a failing character drives `stat` high for exactly the clock in which its replacement is on `dout`.
- R4: With checking on, a failing character is replaced on `dout` by `BAD_CODE` (default 10'h2F8), in both modes.
- R5: With checking off and self-test off, `stat` stays low.
- R6: In self-test mode, parity errors do not appear on `stat`.
- R7: Counting from the edge on which `bist_en` is first seen high (entry edge, no pulse), `stat` is high after every 511th following edge with `bist_en` high, and low after every other edge.
- R8: A synchronous reset (`rst` high) drives `dout` to zero and `stat` low, returns to `ST_CHECK` and reseeds the LFSR.
- R9: When `bist_en` drops and rises again, the sequence restarts: the next pulse comes 511 edges after the new entry edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 10 | Captured transmit character |
| par_in | input | 1 | Odd-parity bit for `din` |
| chk_en_n | input | 1 | Parity checking enable, active low |
| bist_en | input | 1 | Self-test mode enable, active high |
| dout | output | 10 | Character toward the shifter, registered |
| stat | output | 1 | Parity-error or self-test pass pulse, registered |

## Verification
The bench goes after the parity polarity. A design that checks for even parity would replace every good character and pass every bad one. It checks that error reporting stops while self-test runs, so a design that leaked parity errors into the test pulse stream would show extra pulses. It checks the 511-character spacing from the entry edge, both on first entry and after a drop and re-entry of the enable. An off-by-one LFSR seed or a missing reseed shifts every later pulse. Passthrough with checking off is also covered, where a design that substituted anyway would corrupt good data.

// File: rtl/txg_pkg.sv
package txg_pkg;
    localparam int CHAR_W = 10;
    localparam int LFSR_W = 9;
    localparam logic [LFSR_W-1:0] LFSR_SEED = '1;
    localparam logic [CHAR_W-1:0] BAD_CODE_DEF = 10'h2F8;

    typedef enum logic {
        ST_CHECK = 1'b0,
        ST_TEST  = 1'b1
    } guard_state_t;
endpackage

// File: rtl/txg_parity.sv
module txg_parity #(
    parameter int W = txg_pkg::CHAR_W
) (
    input  logic [W-1:0] data,
    input  logic         par,
    output logic         bad
);
    logic total;
    assign total = ^{data, par};
    assign bad   = ~total;
endmodule

// File: rtl/txg_lfsr.sv
module txg_lfsr #(
    parameter int W = txg_pkg::LFSR_W,
    parameter logic [W-1:0] SEED = txg_pkg::LFSR_SEED
) (
    input  logic         clk,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    logic [W-1:0] q;
    logic         fb;

    assign fb   = q[W-1] ^ q[W-5];
    assign nxt  = {q[W-2:0], fb};
    assign wrap = (nxt == SEED);

    always_ff @(posedge clk) begin
        if (load) begin
            q <= SEED;
        end else if (step) begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/tx_char_guard.sv
module tx_char_guard
    import txg_pkg::*;
#(
    parameter int                 DATA_W   = CHAR_W,
    parameter logic [DATA_W-1:0]  BAD_CODE = BAD_CODE_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              par_in,
    input  logic              chk_en_n,
    input  logic              bist_en,
    output logic [DATA_W-1:0] dout,
    output logic              stat
);
    guard_state_t st, st_nx;
    logic         par_bad;
    logic         err_flag;
    logic         lfsr_load;
    logic         lfsr_step;
    logic         lfsr_wrap;
    logic [LFSR_W-1:0] lfsr_nxt;

    txg_parity #(.W(DATA_W)) u_par (
        .data (din),
        .par  (par_in),
        .bad  (par_bad)
    );

    assign err_flag = ~chk_en_n & par_bad;

    // START reseeds, steady test steps, anything else holds the seed
    assign lfsr_load = rst | ~bist_en | (st == ST_CHECK);
    assign lfsr_step = (st == ST_TEST) & bist_en;

    txg_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
        .clk  (clk),
        .load (lfsr_load),
        .step (lfsr_step),
        .nxt  (lfsr_nxt),
        .wrap (lfsr_wrap)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_CHECK: if (bist_en)  st_nx = ST_TEST;   // START
            ST_TEST:  if (!bist_en) st_nx = ST_CHECK;  // STOP
            default:  st_nx = ST_CHECK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_CHECK;
        end else begin
            st <= st_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            stat <= 1'b0;
        end else begin
            dout <= err_flag ? BAD_CODE : din;
            unique case (st)
                ST_CHECK: stat <= bist_en ? 1'b0 : err_flag;
                ST_TEST:  stat <= bist_en ? lfsr_wrap : err_flag;
                default:  stat <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/txg_checker.sv
module txg_checker #(
    parameter int                DATA_W   = 10,
    parameter logic [DATA_W-1:0] BAD_CODE = '0
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] din,
    input logic              par_in,
    input logic              chk_en_n,
    input logic              bist_en,
    input logic [DATA_W-1:0] dout,
    input logic              stat
);
    assert_good_passes_R1: assert property (@(posedge clk) disable iff (rst)
        (!chk_en_n && (^{din, par_in})) |=> (dout == $past(din)));

    assert_off_passes_R2: assert property (@(posedge clk) disable iff (rst)
        chk_en_n |=> (dout == $past(din)));

    assert_err_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (!bist_en && !chk_en_n && !(^{din, par_in})) |=> stat);

    assert_substitute_R4: assert property (@(posedge clk) disable iff (rst)
        (!chk_en_n && !(^{din, par_in})) |=> (dout == BAD_CODE));

    assert_quiet_off_R5: assert property (@(posedge clk) disable iff (rst)
        (!bist_en && chk_en_n) |=> !stat);

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
        (bist_en && stat) |=> !stat);

    assert_reset_state_R8: assert property (@(posedge clk)
        rst |=> (!stat && dout == '0));
endmodule

bind tx_char_guard txg_checker #(.DATA_W(DATA_W), .BAD_CODE(BAD_CODE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .par_in   (par_in),
    .chk_en_n (chk_en_n),
    .bist_en  (bist_en),
    .dout     (dout),
    .stat     (stat)
);

// File: tb/tb_tx_char_guard.sv
module tb_tx_char_guard;
    localparam logic [9:0] BAD = 10'h2F8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] din = '0;
    logic       par_in = 1'b0;
    logic       chk_en_n = 1'b1;
    logic       bist_en = 1'b0;
    logic [9:0] dout;
    logic       stat;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    logic [9:0] exp_d = '0;
    logic       exp_s = 1'b0;
    bit         in_test = 0;
    bit         reentered = 0;
    int         tcnt = 0;
    string      tag_d = "R8";
    string      tag_s = "R8";

    tx_char_guard dut (
        .clk(clk), .rst(rst), .din(din), .par_in(par_in),
        .chk_en_n(chk_en_n), .bist_en(bist_en), .dout(dout), .stat(stat)
    );

    always #2 clk = ~clk;

    // behavioural reference, evaluated from the sampled inputs
    always @(posedge clk) begin
        bit bad_par;
        bad_par = ((($countones(din) + int'(par_in)) % 2) == 0);
        cycles++;
        if (rst) begin
            exp_d = '0; exp_s = 0; in_test = 0; tcnt = 0;
            tag_d = "R8"; tag_s = "R8";
        end else begin
            if (!chk_en_n && bad_par) begin exp_d = BAD; tag_d = "R4"; end
            else begin exp_d = din; tag_d = chk_en_n ? "R2" : "R1"; end
            if (bist_en) begin
                if (!in_test) begin in_test = 1; tcnt = 0; exp_s = 0; end
                else begin tcnt++; exp_s = (tcnt % 511 == 0); end
                tag_s = reentered ? "R9" : (bad_par && !chk_en_n ? "R6" : "R7");
            end else begin
                if (in_test) reentered = 1;
                in_test = 0;
                exp_s = !chk_en_n && bad_par;
                tag_s = chk_en_n ? "R5" : "R3";
            end
        end
    end

    always @(negedge clk) begin
        if (cycles > 0 && !done) begin
            checks++;
            if (dout !== exp_d) begin
                errors++;
                $display("FAIL %s dout actual=%h expected=%h", tag_d, dout, exp_d);
            end
            checks++;
            if (stat !== exp_s) begin
                errors++;
                $display("FAIL %s stat actual=%b expected=%b", tag_s, stat, exp_s);
            end
        end
    end

    task automatic step(input bit force_bad);
        logic [9:0] d;
        d = 10'($urandom);
        din = d;
        par_in = ~(^d) ^ force_bad;
        @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R1/R3/R4: checking on, mixed good and bad parity
        chk_en_n = 0;
        for (int i = 0; i < 200; i++) step(($urandom % 3) == 0);
        for (int i = 0; i < 4; i++) step(1'b1);
        // R2/R5: checking off, bad parity passes quietly
        chk_en_n = 1;
        for (int i = 0; i < 100; i++) step(($urandom % 2) == 0);
        // R6/R7: self-test with parity errors present
        chk_en_n = 0; bist_en = 1;
        for (int i = 0; i < 1200; i++) step(($urandom % 4) == 0);
        // R9: drop and re-enter
        bist_en = 0;
        for (int i = 0; i < 3; i++) step(1'b1);
        bist_en = 1;
        for (int i = 0; i < 600; i++) step(($urandom % 4) == 0);
        // R8: reset in the middle of a test run
        rst = 1;
        step(1'b1); step(1'b0);
        rst = 0; bist_en = 0;
        for (int i = 0; i < 20; i++) step(($urandom % 2) == 0);
        finish_run();
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end
endmodule